// File: doc/BRIEF.md
# Dual-Mode Reload Down-Counter Output Timer

This block is a down-counting output timer with a toggling output flip-flop and two reload values. It runs in one of two modes. In single-shot mode it produces one two-phase waveform: the first phase length comes from the first reload value and the second phase length comes from the second reload value. It then halts by itself. In continuous mode it counts down from a value written into the counter. After that it reloads from the first reload value on every underflow, so it produces a steady train of equal-width pulses.

Software programs the block through a single-cycle register write port. Counting advances only on cycles where a count-clock enable strobe is high. A run starts in one of two ways: software sets the enable bit, or an external trigger pulse arrives (for example another timer's wrap event). A software disable halts the count on the next edge, without waiting for the end of the output period. The outputs are the flip-flop level and a one-cycle interrupt pulse. The counter value and the run flag are also visible at the ports.

Top module: `dual_reload_timer`

## Requirements
- R1: After synchronous reset, `tmr_out`, `irq` and `running` are low and `cnt_value` is 0.
- R2: While the timer is idle, a write to address 1 loads `cnt_value` from `wr_data`. A write to address 0 (control) stores the mode (bit 1: 1 = single-shot, 0 = continuous) and presets `tmr_out` to bit 2. If bit 0 of that control write is 0, the timer stays idle.
- R3: In single-shot mode, a start sets `running` without toggling `tmr_out`. The first count strobe after the start loads `cnt_value` from reload 0 (address 2).
- R4: In single-shot mode, the first underflow does three things: it loads `cnt_value` from reload 1 (address 3), toggles `tmr_out`, and raises no interrupt. An underflow is a count strobe that arrives while the count is 0.
- R5: In single-shot mode, the second underflow toggles `tmr_out`, pulses `irq` for one cycle and clears `running`. `cnt_value` then stays at 0.
- R6: Each phase lasts the programmed reload value plus one count strobe.
- R7: In continuous mode, the start toggles `tmr_out` in the cycle after the control write. Counting then begins from the value written to the counter.
- R8: In continuous mode, every underflow reloads `cnt_value` from reload 0, toggles `tmr_out` and pulses `irq` in the same cycle.
- R9: A pulse on `ext_start` while idle starts the timer in the stored mode. While the timer is running, the pulse has no effect.
- R10: A control write with bit 0 clear stops a running timer on the next edge. The count freezes, `tmr_out` holds, and no interrupt is raised, even if a count strobe arrives in the same cycle.
- R11: While `cnt_tick` is low, `cnt_value` holds.
- R12: While the timer is running, counter writes have no effect, and the mode and preset fields of a control write that keeps bit 0 set have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 counter, 2 reload 0, 3 reload 1 |
| wr_data | input | CNT_W | Write data |
| cnt_tick | input | 1 | Count-clock enable strobe |
| ext_start | input | 1 | External start trigger |
| tmr_out | output | 1 | Output flip-flop level |
| irq | output | 1 | Interrupt request pulse |
| cnt_value | output | CNT_W | Current counter value |
| running | output | 1 | Timer is counting |

## Verification
A wrong phase register shows up at the ports within one count strobe. The wrong reload value appears on `cnt_value`, or an interrupt appears on the first underflow, or `running` stays high after the second underflow. A wrong output flip-flop is visible in the cycle right after a start or an underflow, because every toggle is tied to one of those edges. The bench runs a behavioural reference model and compares all four outputs with it on every clock, so any divergence is reported in the first cycle it occurs.

// File: rtl/drt_pkg.sv
package drt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_FIRST,
        PH_SECOND,
        PH_LOOP
    } phase_e;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_COUNT = 2'd1,
        A_RLD0  = 2'd2,
        A_RLD1  = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN_BIT      = 0;
    localparam int CTRL_ONESHOT_BIT = 1;
    localparam int CTRL_PRESET_BIT  = 2;

    typedef struct packed {
        logic start;
        logic stop;
        logic oneshot;
        logic preset_we;
        logic preset_val;
        logic cnt_we;
    } cmd_t;

    typedef struct packed {
        logic underflow;
        logic irq_evt;
        logic start_toggle;
    } evt_t;

    function automatic logic is_counting(input phase_e ph);
        return (ph == PH_FIRST) || (ph == PH_SECOND) || (ph == PH_LOOP);
    endfunction

endpackage

// File: rtl/drt_regs.sv
module drt_regs
    import drt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_start,
    input  logic             running,
    output cmd_t             cmd,
    output logic [CNT_W-1:0] reload0,
    output logic [CNT_W-1:0] reload1
);

    logic mode_q;
    logic ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    always_comb begin
        cmd            = '0;
        cmd.start      = !running && (ctrl_wr ? wr_data[CTRL_EN_BIT] : ext_start);
        cmd.stop       = running && ctrl_wr && !wr_data[CTRL_EN_BIT];
        cmd.oneshot    = ctrl_wr ? wr_data[CTRL_ONESHOT_BIT] : mode_q;
        cmd.preset_we  = !running && ctrl_wr;
        cmd.preset_val = wr_data[CTRL_PRESET_BIT];
        cmd.cnt_we     = !running && wr_en && (wr_addr == A_COUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            reload0 <= '0;
            reload1 <= '0;
        end else begin
            if (cmd.preset_we)
                mode_q <= wr_data[CTRL_ONESHOT_BIT];
            if (wr_en && (wr_addr == A_RLD0))
                reload0 <= wr_data;
            if (wr_en && (wr_addr == A_RLD1))
                reload1 <= wr_data;
        end
    end

endmodule

// File: rtl/drt_seq.sv
module drt_seq
    import drt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] reload0,
    input  logic [CNT_W-1:0] reload1,
    output logic [CNT_W-1:0] cnt_value,
    output logic             running,
    output evt_t             evt
);

    phase_e           phase_q;
    logic             at_zero;
    logic             step;

    assign at_zero = (cnt_value == '0);
    assign step    = cnt_tick && !cmd.stop;
    assign running = (phase_q != PH_IDLE);

    always_comb begin
        evt              = '0;
        evt.underflow    = step && is_counting(phase_q) && at_zero;
        evt.irq_evt      = evt.underflow && (phase_q != PH_FIRST);
        evt.start_toggle = cmd.start && !cmd.oneshot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_value <= '0;
        end else if (cmd.start) begin
            phase_q <= cmd.oneshot ? PH_LOAD : PH_LOOP;
        end else if (cmd.stop) begin
            phase_q <= PH_IDLE;
        end else if (phase_q == PH_IDLE) begin
            if (cmd.cnt_we)
                cnt_value <= wr_data;
        end else if (step) begin
            unique case (phase_q)
                PH_LOAD: begin
                    cnt_value <= reload0;
                    phase_q   <= PH_FIRST;
                end
                PH_FIRST: begin
                    if (at_zero) begin
                        cnt_value <= reload1;
                        phase_q   <= PH_SECOND;
                    end else begin
                        cnt_value <= cnt_value - 1'b1;
                    end
                end
                PH_SECOND: begin
                    if (at_zero)
                        phase_q <= PH_IDLE;
                    else
                        cnt_value <= cnt_value - 1'b1;
                end
                PH_LOOP: begin
                    if (at_zero)
                        cnt_value <= reload0;
                    else
                        cnt_value <= cnt_value - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/drt_outff.sv
module drt_outff
    import drt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  evt_t evt,
    output logic tmr_out,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_out <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= evt.irq_evt;
            if (cmd.preset_we)
                tmr_out <= cmd.preset_val ^ evt.start_toggle;
            else if (evt.start_toggle || evt.underflow)
                tmr_out <= !tmr_out;
        end
    end

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cnt_tick,
    input  logic             ext_start,
    output logic             tmr_out,
    output logic             irq,
    output logic [CNT_W-1:0] cnt_value,
    output logic             running
);

    cmd_t             cmd;
    evt_t             evt;
    logic [CNT_W-1:0] reload0;
    logic [CNT_W-1:0] reload1;

    drt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ext_start (ext_start),
        .running   (running),
        .cmd       (cmd),
        .reload0   (reload0),
        .reload1   (reload1)
    );

    drt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .cnt_tick  (cnt_tick),
        .wr_data   (wr_data),
        .reload0   (reload0),
        .reload1   (reload1),
        .cnt_value (cnt_value),
        .running   (running),
        .evt       (evt)
    );

    drt_outff u_out (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .evt     (evt),
        .tmr_out (tmr_out),
        .irq     (irq)
    );

endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             cnt_tick,
    input logic             tmr_out,
    input logic             irq,
    input logic [CNT_W-1:0] cnt_value,
    input logic             running
);

    // R8 / R5: every interrupt coincides with an output toggle
    assert_irq_with_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (tmr_out != $past(tmr_out)));

    // R5: an interrupt only follows a count strobe seen while running
    assert_irq_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(running) && $past(cnt_tick)));

    // R11: without a strobe the count does not move while running
    assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(running) && !$past(cnt_tick)) |-> $stable(cnt_value));

    // R10: leaving the running state never changes the count
    assert_freeze_on_stop_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(running) && !running) |-> $stable(cnt_value));

    // R2: an idle timer with no writes keeps its output level
    assert_idle_out_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(running) && !running && !$past(wr_en)) |-> $stable(tmr_out));

endmodule

bind dual_reload_timer drt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .cnt_tick  (cnt_tick),
    .tmr_out   (tmr_out),
    .irq       (irq),
    .cnt_value (cnt_value),
    .running   (running)
);

// File: tb/dual_reload_timer_test.sv
`timescale 1ns/1ps
module dual_reload_timer_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         cnt_tick = 1'b0;
    logic         ext_start = 1'b0;
    logic         tmr_out;
    logic         irq;
    logic [W-1:0] cnt_value;
    logic         running;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dual_reload_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_tick(cnt_tick), .ext_start(ext_start), .tmr_out(tmr_out), .irq(irq),
        .cnt_value(cnt_value), .running(running)
    );

    // behavioural reference: phase 0 idle, 1 awaiting load, 2 first, 3 second, 4 loop
    int m_cnt, m_r0, m_r1, m_ph;
    bit m_single, m_out, m_irq;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_r0 = 0; m_r1 = 0; m_ph = 0;
            m_single = 0; m_out = 0; m_irq = 0;
        end else begin
            bit ctrl, go;
            m_irq = 0;
            ctrl  = wr_en && (wr_addr == 2'd0);
            if (m_ph == 0) begin
                go = 0;
                if (ctrl) begin
                    m_single = wr_data[1];
                    m_out    = wr_data[2];
                    go       = wr_data[0];
                end else if (wr_en && wr_addr == 2'd1) begin
                    m_cnt = int'(wr_data);
                end else if (ext_start) begin
                    go = 1;
                end
                if (go) begin
                    if (m_single) m_ph = 1;
                    else begin m_ph = 4; m_out = !m_out; end
                end
            end else if (ctrl && !wr_data[0]) begin
                m_ph = 0;
            end else if (cnt_tick) begin
                if (m_ph == 1) begin
                    m_cnt = m_r0; m_ph = 2;
                end else if (m_cnt == 0) begin
                    m_out = !m_out;
                    if (m_ph == 2) begin m_cnt = m_r1; m_ph = 3; end
                    else if (m_ph == 3) begin m_ph = 0; m_irq = 1; end
                    else begin m_cnt = m_r0; m_irq = 1; end
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (wr_en && wr_addr == 2'd2) m_r0 = int'(wr_data);
            if (wr_en && wr_addr == 2'd3) m_r1 = int'(wr_data);
        end
    end

    // per-cycle comparison against the model (R3/R4/R5/R7/R8/R11)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(cnt_value) != m_cnt || running != (m_ph != 0) ||
                tmr_out != m_out || irq != m_irq) begin
                errors++;
                $display("FAIL R3/R4/R5/R7/R8/R11 model compare t=%0t: cnt=%0d run=%0b out=%0b irq=%0b expected cnt=%0d run=%0b out=%0b irq=%0b",
                         $time, cnt_value, running, tmr_out, irq, m_cnt, (m_ph != 0), m_out, m_irq);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected below 5000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock with the given inputs; returns 1 ns after the edge
    task automatic cyc(input bit w, input logic [1:0] a, input int d, input bit t, input bit e);
        wr_en = w; wr_addr = a; wr_data = d[W-1:0]; cnt_tick = t; ext_start = e;
        @(posedge clk); #1;
        wr_en = 0; cnt_tick = 0; ext_start = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 2'd0, 0, 1, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        chk("R1 out", tmr_out, 0);
        chk("R1 irq", irq, 0);
        chk("R1 running", running, 0);
        chk("R1 count", cnt_value, 0);

        // single-shot: reload0=3, reload1=1
        cyc(1, 2'd2, 3, 0, 0);
        cyc(1, 2'd3, 1, 0, 0);
        cyc(1, 2'd0, 3, 0, 0);
        chk("R3 running after start", running, 1);
        chk("R3 no toggle at start", tmr_out, 0);
        ticks(1);
        chk("R3 load reload0", cnt_value, 3);
        ticks(3);
        chk("R6 phase one not over", tmr_out, 0);
        ticks(1);
        chk("R4 first underflow toggles", tmr_out, 1);
        chk("R4 loads reload1", cnt_value, 1);
        chk("R4 no irq", irq, 0);
        ticks(1);
        chk("R6 phase two count", cnt_value, 0);
        ticks(1);
        chk("R5 irq pulse", irq, 1);
        chk("R5 second toggle", tmr_out, 0);
        chk("R5 running cleared", running, 0);
        ticks(1);
        chk("R5 irq one cycle", irq, 0);
        chk("R5 count held", cnt_value, 0);

        // continuous: count=2, reload0=1, preset high
        cyc(1, 2'd1, 2, 0, 0);
        chk("R2 counter write", cnt_value, 2);
        cyc(1, 2'd2, 1, 0, 0);
        cyc(1, 2'd0, 5, 0, 0);
        chk("R7 start toggles preset", tmr_out, 0);
        chk("R7 count from written value", cnt_value, 2);
        ticks(2);
        chk("R7 counting down", cnt_value, 0);
        ticks(1);
        chk("R8 reload0 on underflow", cnt_value, 1);
        chk("R8 toggle", tmr_out, 1);
        chk("R8 irq", irq, 1);
        cyc(0, 2'd0, 0, 0, 0);
        cyc(0, 2'd0, 0, 0, 0);
        chk("R11 hold without tick", cnt_value, 1);
        cyc(1, 2'd1, 9, 0, 0);
        chk("R12 counter write ignored", cnt_value, 1);
        cyc(1, 2'd0, 7, 0, 0);
        chk("R12 preset ignored while running", tmr_out, 1);
        cyc(0, 2'd0, 0, 0, 1);
        chk("R9 trigger ignored while running", cnt_value, 1);
        ticks(2);
        chk("R8 second irq", irq, 1);
        chk("R6 width reload0+1", tmr_out, 0);
        ticks(1);
        cyc(1, 2'd0, 0, 1, 0);
        chk("R10 stopped", running, 0);
        chk("R10 count frozen", cnt_value, 0);
        chk("R10 no irq", irq, 0);
        chk("R10 output held", tmr_out, 0);

        // external trigger in single-shot mode
        cyc(1, 2'd2, 0, 0, 0);
        cyc(1, 2'd3, 2, 0, 0);
        cyc(1, 2'd0, 2, 0, 0);
        chk("R2 enable clear stays idle", running, 0);
        cyc(0, 2'd0, 0, 0, 1);
        chk("R9 trigger starts", running, 1);
        chk("R9 single-shot no start toggle", tmr_out, 0);
        ticks(1);
        chk("R3 load reload0 zero", cnt_value, 0);
        ticks(1);
        chk("R6 one-strobe phase", tmr_out, 1);
        chk("R4 reload1 loaded", cnt_value, 2);
        ticks(1);
        cyc(1, 2'd0, 0, 0, 0);
        chk("R10 stop mid phase", running, 0);
        chk("R10 count kept", cnt_value, 1);
        ticks(3);
        chk("R10 idle ignores ticks", cnt_value, 1);

        finish_run();
    end

endmodule